// File: doc/BRIEF.md
# Line-Paced VGA Sync Generator

This block produces horizontal and vertical sync for a 640x480 raster from a pixel-clock enable. The system clock is faster than the pixel rate. A one-cycle enable pulse marks each pixel clock.

A horizontal timer counts enabled pixels across a line. The line is made of an active-plus-front-porch span, a sync pulse and a back porch. On the last back-porch pixel the timer raises an end-of-line event.

A vertical timer never looks at the pixel count. It moves one line forward each time it consumes an end-of-line event. When the line being entered is a vertically active line, it also raises a line-start strobe, so that a separate pixel engine can begin that row.

The active-plus-front-porch pixel length and the active line count are run-time inputs. The remaining porch and pulse lengths are fixed by parameters.

Top module: `vga_line_sync`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, hsync_o and vsync_o are 1 and eol_o and line_start_o are 0. Counting starts at pixel 0 of line 0, and both timers leave reset on the same clock.
- R2: A line lasts h_run_len_i + 96 + 48 enabled pixels. Pixels are numbered from 0. hsync_o is 0 exactly while the current pixel index lies in [h_run_len_i, h_run_len_i+96), and 1 otherwise. With h_run_len_i = 656 a line is 800 pixels and hsync_o is high for 704 of them.
- R3: eol_o is a one-clock pulse raised on the clock edge that samples pix_en_i high on the last pixel of a line, h_run_len_i+143. There is exactly one pulse per line.
- R4: A frame lasts v_act_len_i + 10 + 2 + 33 lines. vsync_o is 0 exactly on lines v_act_len_i+10 and v_act_len_i+11, and 1 otherwise. vsync_o changes only on the clock edge that raises eol_o.
- R5: line_start_o is a one-clock pulse, coincident with eol_o, raised only when the line being entered has an index below v_act_len_i. A frame therefore carries v_act_len_i strobes and none during vertical blanking. Line 0 directly after reset carries no strobe.
- R6: When pix_en_i is 0 no position advances and no output changes, whatever the pattern of enables.
- R7: h_run_len_i and v_act_len_i are used as run-time lengths. They may be changed while rst_ni is low, and the timing after reset follows the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pix_en_i | input | 1 | One-cycle pixel-clock enable |
| h_run_len_i | input | H_W | Active plus front-porch length in pixels |
| v_act_len_i | input | V_W | Vertical active length in lines |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| eol_o | output | 1 | End-of-line event, one clock |
| line_start_o | output | 1 | Start of a vertically active line, one clock |

## Verification
A wrong horizontal position shows up at hsync_o, and on the next line boundary at eol_o. That can be as late as one full line, so the bench compares every output on every clock against a behavioural position model.

A wrong line count leaves hsync_o untouched. It appears only as a misplaced vsync_o pulse or a missing or extra line_start_o, which can take up to a frame to show. For that reason the bench runs whole frames with short run-time lengths and also tallies the strobes, the events and the vsync low time per frame.

An irregular enable pattern exposes any counter that advances without an enable.

// File: rtl/vga_sync_pkg.sv
package vga_sync_pkg;
  localparam int POS_W = 12;
  typedef logic [POS_W-1:0] pos_t;

  function automatic logic in_span(pos_t p, pos_t lo, pos_t len);
    return (p >= lo) && (p < lo + len);
  endfunction
endpackage

// File: rtl/vga_h_timer.sv
module vga_h_timer
  import vga_sync_pkg::*;
#(
  parameter int H_W    = 10,
  parameter int H_SYNC = 96,
  parameter int H_BACK = 48
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pix_en_i,
  input  logic [H_W-1:0] run_len_i,
  output logic           line_done_o,
  output logic           hsync_o,
  output logic           eol_o
);
  localparam pos_t SYNC_LEN = pos_t'(H_SYNC);
  localparam pos_t TAIL_LEN = pos_t'(H_SYNC + H_BACK);

  pos_t h_cnt, h_nxt, run, last;
  logic at_last, hsync_q, eol_q;

  assign run     = pos_t'(run_len_i);
  assign last    = run + TAIL_LEN - pos_t'(1);
  assign at_last = (h_cnt == last);
  assign h_nxt   = at_last ? '0 : h_cnt + pos_t'(1);

  assign line_done_o = pix_en_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_cnt   <= '0;
      hsync_q <= 1'b1;
      eol_q   <= 1'b0;
    end else begin
      eol_q <= line_done_o;
      if (pix_en_i) begin
        h_cnt   <= h_nxt;
        hsync_q <= !in_span(h_nxt, run, SYNC_LEN);
      end
    end
  end

  assign hsync_o = hsync_q;
  assign eol_o   = eol_q;

  // R3
  eol_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_q |=> !eol_q);
  // R6
  h_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> $stable(h_cnt));
  // R6
  hsync_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> $stable(hsync_q));
  // R2
  h_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_cnt <= last);
endmodule

// File: rtl/vga_v_timer.sv
module vga_v_timer
  import vga_sync_pkg::*;
#(
  parameter int V_W     = 10,
  parameter int V_FRONT = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BACK  = 33
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           line_done_i,
  input  logic [V_W-1:0] act_len_i,
  output logic           vsync_o,
  output logic           line_start_o
);
  localparam pos_t FRONT_LEN = pos_t'(V_FRONT);
  localparam pos_t SYNC_LEN  = pos_t'(V_SYNC);
  localparam pos_t BLANK_LEN = pos_t'(V_FRONT + V_SYNC + V_BACK);

  pos_t v_cnt, v_nxt, act, last;
  logic vsync_q, ls_q;

  assign act   = pos_t'(act_len_i);
  assign last  = act + BLANK_LEN - pos_t'(1);
  assign v_nxt = (v_cnt == last) ? '0 : v_cnt + pos_t'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_cnt   <= '0;
      vsync_q <= 1'b1;
      ls_q    <= 1'b0;
    end else begin
      ls_q <= 1'b0;
      if (line_done_i) begin
        v_cnt   <= v_nxt;
        vsync_q <= !in_span(v_nxt, act + FRONT_LEN, SYNC_LEN);
        ls_q    <= (v_nxt < act);
      end
    end
  end

  assign vsync_o      = vsync_q;
  assign line_start_o = ls_q;

  // R4
  vsync_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_done_i |=> $stable(vsync_q));
  // R5
  ls_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_q |-> vsync_q);
  // R4
  v_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_cnt <= last);
endmodule

// File: rtl/vga_line_sync.sv
module vga_line_sync #(
  parameter int H_W     = 10,
  parameter int V_W     = 10,
  parameter int H_SYNC  = 96,
  parameter int H_BACK  = 48,
  parameter int V_FRONT = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BACK  = 33
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pix_en_i,
  input  logic [H_W-1:0] h_run_len_i,
  input  logic [V_W-1:0] v_act_len_i,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           eol_o,
  output logic           line_start_o
);
  logic line_done;

  vga_h_timer #(.H_W(H_W), .H_SYNC(H_SYNC), .H_BACK(H_BACK)) u_h (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pix_en_i    (pix_en_i),
    .run_len_i   (h_run_len_i),
    .line_done_o (line_done),
    .hsync_o     (hsync_o),
    .eol_o       (eol_o)
  );

  vga_v_timer #(.V_W(V_W), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK)) u_v (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_done_i  (line_done),
    .act_len_i    (v_act_len_i),
    .vsync_o      (vsync_o),
    .line_start_o (line_start_o)
  );

  // R5
  ls_eol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |-> eol_o);
  // R4
  vsync_eol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsync_o != $past(vsync_o)) |-> eol_o);
endmodule

// File: tb/sim_vga_line_sync.sv
module sim_vga_line_sync;
  logic clk = 1'b0, rst_ni = 1'b0, pix_en = 1'b0;
  logic [9:0] h_run = 10'd656, v_act = 10'd480;
  logic hsync, vsync, eol, ls;
  int checks = 0, fails = 0;
  int mode = 0, cyc = 0;
  int hpos = 0, vpos = 0, e_eol = 0, e_ls = 0;
  int en_cnt = 0, eol_cnt = 0, ls_cnt = 0, vlow_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vga_line_sync u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pix_en_i(pix_en),
    .h_run_len_i(h_run), .v_act_len_i(v_act),
    .hsync_o(hsync), .vsync_o(vsync), .eol_o(eol), .line_start_o(ls)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // behavioural position model
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hpos = 0; vpos = 0; e_eol = 0; e_ls = 0; en_cnt = 0;
    end else begin
      e_eol = 0; e_ls = 0;
      if (pix_en) begin
        en_cnt++;
        if (hpos == h_run + 143) begin
          hpos = 0; e_eol = 1;
          vpos = (vpos + 1) % (v_act + 45);
          e_ls = (vpos < v_act) ? 1 : 0;
        end else hpos++;
      end
    end
  end

  // compare every clock
  always @(negedge clk) begin
    if (rst_ni) begin
      chk("R2 hsync", hsync, (hpos >= h_run && hpos < h_run + 96) ? 0 : 1);
      chk("R4 vsync", vsync, (vpos >= v_act + 10 && vpos < v_act + 12) ? 0 : 1);
      chk("R3 eol", eol, e_eol);
      chk("R5 line_start", ls, e_ls);
      if (eol) eol_cnt++;
      if (ls) ls_cnt++;
      if (!vsync) vlow_cnt++;
    end
  end

  // enable driver: mode 0 regular 1-in-4, mode 1 irregular
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (mode == 0) pix_en = (cyc % 4 == 0);
      else pix_en = (cyc % 7 == 0) || (cyc % 5 == 2) || (cyc % 11 == 3);
    end
  end

  task automatic do_reset(int hr, int va, int md);
    @(negedge clk);
    rst_ni = 1'b0;
    h_run = 10'(hr); v_act = 10'(va); mode = md;
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    chk("R1 hsync rst", hsync, 1);
    chk("R1 vsync rst", vsync, 1);
    chk("R1 eol rst", eol, 0);
    chk("R1 ls rst", ls, 0);
    rst_ni = 1'b1;
    eol_cnt = 0; ls_cnt = 0; vlow_cnt = 0;
    @(negedge clk);
    chk("R1 hsync after rst", hsync, 1);
    chk("R1 vsync after rst", vsync, 1);
  endtask

  initial begin
    // full-size timing for three lines (R2: 800-pixel line, 704 high)
    do_reset(656, 480, 0);
    wait (en_cnt == 3 * 800);
    @(negedge clk); #1;
    chk("R3 eol per line 640x480", eol_cnt, 3);
    chk("R5 strobes first lines", ls_cnt, 3);

    // two full short frames (R4, R5, R7)
    do_reset(20, 8, 0);
    wait (en_cnt == 2 * 164 * 53);
    @(negedge clk); #1;
    chk("R3 eol count 2 frames", eol_cnt, 106);
    chk("R5 strobe count 2 frames", ls_cnt, 16);
    chk("R4 vsync low clocks", vlow_cnt, 2 * 2 * 164 * 4);

    // irregular enables, other lengths (R6, R7)
    do_reset(5, 3, 1);
    wait (en_cnt == 2 * 149 * 48);
    @(negedge clk); #1;
    chk("R6 eol count irregular", eol_cnt, 96);
    chk("R7 strobe count irregular", ls_cnt, 6);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule